// File: doc/BRIEF.md
# UART DMA Request Controller

This block sits beside a low-power UART and decides when to ask a DMA engine to move data. On the receive side it raises a read request when a byte is waiting in the receive buffer. It can optionally hold that request back when the waiting byte arrived with a parity or framing error, so that software can inspect the faulty byte first. On the transmit side it raises a write request under one of two conditions, chosen by a mode bit. It pulses a completion output for each request the DMA engine services.

The block also drives a registered sleep-inhibit line for the power controller. While a wakeup bit is set, a pending request on that path keeps the system out of deep sleep. A request held back by error suppression does not keep the system awake.

A small source multiplexer feeds the UART's receive shifter. It selects either the external receive pin or one of several internal event channels, so that an analogue comparator output, for example, can be received as serial data.

The receive path is a four-state machine:
- RX_IDLE goes to RX_PEND when the buffer is full and the byte is clean or suppression is off.
- RX_IDLE goes to RX_HELD when the buffer is full, suppression is on and the byte has an error.
- RX_PEND goes to RX_DRAIN when the read is acknowledged.
- RX_PEND goes to RX_IDLE when the buffer empties without DMA.
- RX_HELD goes to RX_IDLE when the buffer empties.
- RX_DRAIN always goes to RX_IDLE after one cycle.

The transmit path is a three-state machine:
- TX_IDLE goes to TX_PEND when the write condition holds.
- TX_PEND goes to TX_WAIT on a write acknowledge.
- TX_PEND goes to TX_IDLE when the condition drops.
- TX_WAIT always goes to TX_IDLE after one cycle.

Top module: `uart_dma_req_ctrl`

## Requirements
- R1: `rx_serial` equals `rx_pin` when `cfg_rx_evt` is 0. When `cfg_rx_evt` is 1, it equals bit `cfg_evt_sel` of `evt_in`, and is 0 if the index is out of range.
- R2: `dma_rd_req` rises one cycle after `rxbuf_full` is sampled high in RX_IDLE, unless the byte is suppressed. It falls one cycle after `rxbuf_full` is sampled low without an acknowledge.
- R3: A sampled `dma_rd_ack` while `dma_rd_req` is high clears `dma_rd_req` on the next clock and pulses `rd_done` high for one cycle. After one RX_DRAIN cycle, the request may rise again.
- R4: With `cfg_err_hold` = 1, a byte that is full with `rxbuf_perr` or `rxbuf_ferr` set produces no read request. That byte holds off further requests until `rxbuf_full` falls.
- R5: Receive errors and error suppression never affect `dma_wr_req` or `wr_done`.
- R6: With `cfg_tx_full_idle` = 0, `dma_wr_req` rises one cycle after `txbuf_empty` is sampled high. It falls one cycle after `txbuf_empty` is sampled low.
- R7: With `cfg_tx_full_idle` = 1, the write condition is `txbuf_empty` AND `txshift_empty`.
- R8: A sampled `dma_wr_ack` while `dma_wr_req` is high clears `dma_wr_req` on the next clock and pulses `wr_done` for one cycle.
- R9: `sleep_block` is registered. On each clock it loads (`cfg_rx_wake` AND `dma_rd_req`) OR (`cfg_tx_wake` AND `dma_wr_req`), using the values sampled at that clock.
- R10: While `rst_n` is low, `dma_rd_req`, `dma_wr_req`, `rd_done`, `wr_done` and `sleep_block` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_evt | input | 1 | 1 selects an event channel as receive input |
| cfg_evt_sel | input | SEL_W | Event channel index |
| cfg_tx_full_idle | input | 1 | 1: write request needs buffer and shifter empty |
| cfg_err_hold | input | 1 | Suppress read requests for erroneous bytes |
| cfg_rx_wake | input | 1 | Pending read request blocks deep sleep |
| cfg_tx_wake | input | 1 | Pending write request blocks deep sleep |
| rx_pin | input | 1 | External receive pin |
| evt_in | input | N_EVT | Internal event channels |
| rx_serial | output | 1 | Selected serial input to the receive shifter |
| rxbuf_full | input | 1 | Receive buffer holds a byte |
| rxbuf_perr | input | 1 | Held byte has a parity error |
| rxbuf_ferr | input | 1 | Held byte has a framing error |
| txbuf_empty | input | 1 | Transmit buffer empty |
| txshift_empty | input | 1 | Transmit shifter idle |
| dma_rd_ack | input | 1 | DMA read of receive data |
| dma_wr_ack | input | 1 | DMA write of transmit data |
| dma_rd_req | output | 1 | DMA read request |
| dma_wr_req | output | 1 | DMA write request |
| rd_done | output | 1 | One-cycle pulse: read request serviced |
| wr_done | output | 1 | One-cycle pulse: write request serviced |
| sleep_block | output | 1 | Inhibit deep-sleep entry |

## Verification
Both request paths can be acknowledged in the same clock. When that happens, both completion pulses must fire together, and the sleep-inhibit register must weigh both wakeup terms from the pre-edge request levels.

A second collision is a read acknowledge that coincides with the buffer staying full for a new byte. This must pass through one RX_DRAIN cycle before the request rises again.

Random stimulus is used to provoke these collisions. The acknowledge probabilities are high, and configuration is re-drawn every segment. Every cycle is judged against a cycle-level reference model in the bench that follows the requirements.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_PEND  = 2'd1,
        RX_HELD  = 2'd2,
        RX_DRAIN = 2'd3
    } rx_st_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_PEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_st_e;
endpackage

// File: rtl/rx_src_mux.sv
module rx_src_mux #(
    parameter int N_EVT = 8,
    parameter int SEL_W = 3
) (
    input  logic             use_evt,
    input  logic [SEL_W-1:0] sel,
    input  logic             pin,
    input  logic [N_EVT-1:0] evt,
    output logic             dout
);
    localparam int N_IDX = 1 << SEL_W;

    logic [N_IDX-1:0] evt_ext;

    // Widen the channel vector to every index the select field can name.
    // Indices beyond the last real channel read as 0.
    for (genvar g = 0; g < N_IDX; g++) begin : g_ext
        if (g < N_EVT) begin : g_real
            assign evt_ext[g] = evt[g];
        end else begin : g_pad
            assign evt_ext[g] = 1'b0;
        end
    end

    assign dout = use_evt ? evt_ext[sel] : pin;

    always_comb begin
        a_r1_pin_path : assert (use_evt || (dout == pin));
    end
endmodule

// File: rtl/rx_req_fsm.sv
module rx_req_fsm
    import uart_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_hold,
    input  logic full,
    input  logic perr,
    input  logic ferr,
    input  logic ack,
    output logic req,
    output logic done
);
    rx_st_e st_q, st_d;

    logic bad;
    assign bad = err_hold && (perr || ferr);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE: begin
                if (full) st_d = bad ? RX_HELD : RX_PEND;
            end
            RX_PEND: begin
                if (ack)       st_d = RX_DRAIN;
                else if (!full) st_d = RX_IDLE;
            end
            RX_HELD: begin
                if (!full) st_d = RX_IDLE;
            end
            RX_DRAIN: st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (st_q == RX_PEND) && ack;
    end

    assign req = (st_q == RX_PEND);

    a_r3_drop_after_ack : assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (!req && done));

    a_r4_no_req_on_err : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_IDLE && full && err_hold && (perr || ferr)) |=> !req);

    a_r2_rise_needs_full : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(full));
endmodule

// File: rtl/tx_req_fsm.sv
module tx_req_fsm
    import uart_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_idle,
    input  logic buf_empty,
    input  logic sh_empty,
    input  logic ack,
    output logic req,
    output logic done
);
    tx_st_e st_q, st_d;

    logic cond;
    assign cond = full_idle ? (buf_empty && sh_empty) : buf_empty;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: begin
                if (cond) st_d = TX_PEND;
            end
            TX_PEND: begin
                if (ack)        st_d = TX_WAIT;
                else if (!cond) st_d = TX_IDLE;
            end
            TX_WAIT: st_d = TX_IDLE;
            default: st_d = TX_IDLE;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (st_q == TX_PEND) && ack;
    end

    assign req = (st_q == TX_PEND);

    a_r8_drop_after_ack : assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (!req && done));

    a_r7_shift_busy : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_IDLE && full_idle && !sh_empty) |=> !req);

    a_r6_rise_needs_empty : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(buf_empty));
endmodule

// File: rtl/uart_dma_req_ctrl.sv
module uart_dma_req_ctrl #(
    parameter int N_EVT = 8,
    parameter int SEL_W = $clog2(N_EVT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rx_evt,
    input  logic [SEL_W-1:0] cfg_evt_sel,
    input  logic             cfg_tx_full_idle,
    input  logic             cfg_err_hold,
    input  logic             cfg_rx_wake,
    input  logic             cfg_tx_wake,
    input  logic             rx_pin,
    input  logic [N_EVT-1:0] evt_in,
    output logic             rx_serial,
    input  logic             rxbuf_full,
    input  logic             rxbuf_perr,
    input  logic             rxbuf_ferr,
    input  logic             txbuf_empty,
    input  logic             txshift_empty,
    input  logic             dma_rd_ack,
    input  logic             dma_wr_ack,
    output logic             dma_rd_req,
    output logic             dma_wr_req,
    output logic             rd_done,
    output logic             wr_done,
    output logic             sleep_block
);
    rx_src_mux #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_mux (
        .use_evt (cfg_rx_evt),
        .sel     (cfg_evt_sel),
        .pin     (rx_pin),
        .evt     (evt_in),
        .dout    (rx_serial)
    );

    rx_req_fsm u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_hold (cfg_err_hold),
        .full     (rxbuf_full),
        .perr     (rxbuf_perr),
        .ferr     (rxbuf_ferr),
        .ack      (dma_rd_ack),
        .req      (dma_rd_req),
        .done     (rd_done)
    );

    tx_req_fsm u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_idle (cfg_tx_full_idle),
        .buf_empty (txbuf_empty),
        .sh_empty  (txshift_empty),
        .ack       (dma_wr_ack),
        .req       (dma_wr_req),
        .done      (wr_done)
    );

    // Registered sleep-inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) sleep_block <= 1'b0;
        else        sleep_block <= (cfg_rx_wake && dma_rd_req) ||
                                   (cfg_tx_wake && dma_wr_req);
    end

    a_r9_rx_wake_blocks : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rx_wake && dma_rd_req) |=> sleep_block);

    a_r9_tx_wake_blocks : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_wake && dma_wr_req) |=> sleep_block);

    a_r9_no_wake_no_block : assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rx_wake && !cfg_tx_wake) |=> !sleep_block);

    a_r5_rx_err_no_tx_effect : assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr_req && !dma_wr_ack && txbuf_empty && txshift_empty) |=> dma_wr_req);
endmodule

// File: tb/test_uart_dma_req_ctrl.sv
`timescale 1ns/1ps
module test_uart_dma_req_ctrl;
    localparam int N_EVT = 8;
    localparam int SEL_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rx_evt = 0, cfg_tx_full_idle = 0, cfg_err_hold = 0;
    logic cfg_rx_wake = 0, cfg_tx_wake = 0;
    logic [SEL_W-1:0] cfg_evt_sel = '0;
    logic rx_pin = 0;
    logic [N_EVT-1:0] evt_in = '0;
    logic rxbuf_full = 0, rxbuf_perr = 0, rxbuf_ferr = 0;
    logic txbuf_empty = 1, txshift_empty = 1;
    logic dma_rd_ack = 0, dma_wr_ack = 0;
    logic rx_serial, dma_rd_req, dma_wr_req, rd_done, wr_done, sleep_block;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    uart_dma_req_ctrl #(.N_EVT(N_EVT), .SEL_W(SEL_W)) i_uart_dma_req_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_evt(cfg_rx_evt), .cfg_evt_sel(cfg_evt_sel),
        .cfg_tx_full_idle(cfg_tx_full_idle), .cfg_err_hold(cfg_err_hold),
        .cfg_rx_wake(cfg_rx_wake), .cfg_tx_wake(cfg_tx_wake),
        .rx_pin(rx_pin), .evt_in(evt_in), .rx_serial(rx_serial),
        .rxbuf_full(rxbuf_full), .rxbuf_perr(rxbuf_perr), .rxbuf_ferr(rxbuf_ferr),
        .txbuf_empty(txbuf_empty), .txshift_empty(txshift_empty),
        .dma_rd_ack(dma_rd_ack), .dma_wr_ack(dma_wr_ack),
        .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req),
        .rd_done(rd_done), .wr_done(wr_done), .sleep_block(sleep_block)
    );

    // Reference model, built from the requirements.
    // Receive: 0 idle, 1 pending, 2 held, 3 drain.
    // Transmit: 0 idle, 1 pending, 2 wait.
    int  m_rx = 0, m_tx = 0;
    bit  m_rdd = 0, m_wrd = 0, m_sb = 0;

    function automatic int rx_step(int s, bit full, bit bad, bit ack);
        case (s)
            0:       return full ? (bad ? 2 : 1) : 0;
            1:       return ack ? 3 : (full ? 1 : 0);
            2:       return full ? 2 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int tx_step(int s, bit cnd, bit ack);
        case (s)
            0:       return cnd ? 1 : 0;
            1:       return ack ? 2 : (cnd ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_serial();
        if (!cfg_rx_evt) return rx_pin;
        return (int'(cfg_evt_sel) < N_EVT) ? evt_in[cfg_evt_sel] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx <= 0; m_tx <= 0; m_rdd <= 0; m_wrd <= 0; m_sb <= 0;
        end else begin
            m_sb  <= (cfg_rx_wake && m_rx == 1) || (cfg_tx_wake && m_tx == 1);
            m_rdd <= (m_rx == 1) && dma_rd_ack;
            m_wrd <= (m_tx == 1) && dma_wr_ack;
            m_rx  <= rx_step(m_rx, rxbuf_full,
                             cfg_err_hold && (rxbuf_perr || rxbuf_ferr), dma_rd_ack);
            m_tx  <= tx_step(m_tx,
                             cfg_tx_full_idle ? (txbuf_empty && txshift_empty) : txbuf_empty,
                             dma_wr_ack);
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2/R3/R4 rd_req", dma_rd_req, m_rx == 1);
        chk("R5/R6/R7/R8 wr_req", dma_wr_req, m_tx == 1);
        chk("R3 rd_done", rd_done, m_rdd);
        chk("R8 wr_done", wr_done, m_wrd);
        chk("R9 sleep_block", sleep_block, m_sb);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));

        // R10: reset state, with inputs that would otherwise raise requests.
        rxbuf_full = 1; txbuf_empty = 1; cfg_rx_wake = 1; cfg_tx_wake = 1;
        repeat (3) @(negedge clk);
        chk("R10 rd_req", dma_rd_req, 1'b0);
        chk("R10 wr_req", dma_wr_req, 1'b0);
        chk("R10 rd_done", rd_done, 1'b0);
        chk("R10 wr_done", wr_done, 1'b0);
        chk("R10 sleep_block", sleep_block, 1'b0);
        chk("R1 reset pin path", rx_serial, rx_pin);
        rxbuf_full = 0; cfg_rx_wake = 0; cfg_tx_wake = 0;
        @(negedge clk);
        rst_n = 1;

        // Directed R4: an erroneous byte under suppression gives no request;
        // then both acknowledges collide.
        @(negedge clk); check_all();
        cfg_err_hold = 1; rxbuf_full = 1; rxbuf_ferr = 1; txbuf_empty = 0;
        repeat (3) begin @(negedge clk); check_all(); end
        chk("R4 held byte", dma_rd_req, 1'b0);
        rxbuf_full = 0; rxbuf_ferr = 0;
        @(negedge clk); check_all();
        rxbuf_full = 1; txbuf_empty = 1; cfg_rx_wake = 1; cfg_tx_wake = 1;
        @(negedge clk); check_all();
        chk("R2 clean byte", dma_rd_req, 1'b1);
        dma_rd_ack = 1; dma_wr_ack = 1;
        @(negedge clk); check_all();
        dma_rd_ack = 0; dma_wr_ack = 0;
        chk("R3 dual ack rd_done", rd_done, 1'b1);
        chk("R8 dual ack wr_done", wr_done, 1'b1);
        repeat (3) begin @(negedge clk); check_all(); end

        // Constrained random segments.
        for (int seg = 0; seg < 40; seg++) begin
            cfg_rx_evt       = 1'($urandom_range(1));
            cfg_evt_sel      = SEL_W'($urandom);
            cfg_tx_full_idle = 1'($urandom_range(1));
            cfg_err_hold     = 1'($urandom_range(1));
            cfg_rx_wake      = 1'($urandom_range(1));
            cfg_tx_wake      = 1'($urandom_range(1));
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                check_all();
                if ($urandom_range(9) < 2) rxbuf_full = ~rxbuf_full;
                if ($urandom_range(9) < 2) txbuf_empty = ~txbuf_empty;
                if ($urandom_range(9) < 3) txshift_empty = ~txshift_empty;
                rxbuf_perr = ($urandom_range(9) < 2);
                rxbuf_ferr = ($urandom_range(9) < 2);
                dma_rd_ack = ($urandom_range(9) < 4);
                dma_wr_ack = ($urandom_range(9) < 4);
                rx_pin     = 1'($urandom_range(1));
                evt_in     = N_EVT'($urandom);
                #1;
                chk("R1 rx_serial", rx_serial, exp_serial());
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule